// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block turns one data byte per request into an asynchronous serial frame on a single output line. The line rests high. Each frame has these parts in order: a low start bit, the data bits with the least significant bit first, an optional parity bit, and one or two high stop bits. Three control inputs set the frame format: the character length (7 or 8 bits), the parity mode (none, forced zero, odd or even) and the stop-bit count. The block samples these inputs only while the transmitter is disabled. The format therefore cannot change partway through a frame.

Bytes arrive through a valid/ready handshake. An external baud tick, high for one clock cycle per bit period, moves the frame forward. Each bit ends on a tick, so the start bit may last less than a full period if the tick phase is free-running. Baud generation is not part of this block. A power input and a transmit-enable input gate all activity. Clearing transmit enable drops any frame in progress and returns the line high at once. When the last stop bit of a completed frame ends, a one-cycle completion pulse appears, and the block is ready for the next byte in that same cycle.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, `txd` is 1, `din_ready` is 0 and `tx_done` is 0. `txd` is 1 whenever no frame is in progress.
- R2: `din_ready` is 1 only when `pwr_en` and `tx_en` are both 1 and no frame is in progress. With `pwr_en` at 0, no byte is accepted.
- R3: A byte is accepted on a clock edge where `din_valid` and `din_ready` are both 1. From the next cycle, `txd` carries the start bit (0), then the data bits LSB first. Each bit is held until a clock edge on which `baud_tick` is 1.
- R4: `len8`=0 sends 7 data bits and `len8`=1 sends 8. In 7-bit mode, bit 7 of `din` has no effect on the line or on parity.
- R5: `par_sel` selects the parity bit that follows the data: 2'b00 sends no parity bit, 2'b01 sends 0, 2'b10 sends odd parity, 2'b11 sends even parity. Parity is computed over the configured data bits only.
- R6: `stop2`=0 ends the frame with one stop bit (1) and `stop2`=1 with two.
- R7: `par_sel`, `len8` and `stop2` are captured only on clock edges where `tx_en` is 0. Changes made while `tx_en` is 1 do not affect frames until `tx_en` has been 0 for at least one edge.
- R8: When `tx_en` is cleared, `txd` is 1 in that same cycle and any frame in progress is abandoned without a `tx_done` pulse.
- R9: On the clock edge that ends the last stop bit, `tx_done` goes high for exactly one cycle, and `din_ready` is 1 in that cycle.
- R10: `baud_tick` pulses while no frame is in progress leave `txd` at 1 and produce no `tx_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_en | input | 1 | Block power enable; must be set before tx_en |
| tx_en | input | 1 | Transmit enable; 0 aborts and allows format capture |
| par_sel | input | 2 | Parity mode: 00 none, 01 zero, 10 odd, 11 even |
| len8 | input | 1 | Character length: 0 = 7 bits, 1 = 8 bits |
| stop2 | input | 1 | Stop bits: 0 = one, 1 = two |
| din | input | 8 | Byte to transmit |
| din_valid | input | 1 | din holds a byte to send |
| din_ready | output | 1 | Transmitter can accept a byte |
| baud_tick | input | 1 | One-cycle pulse marking the end of each bit period |
| txd | output | 1 | Serial output, idles high |
| tx_done | output | 1 | One-cycle pulse after the last stop bit |

## Verification
The bench sends 0x81 in 7-bit odd-parity mode. A design that let bit 7 into the data field or the parity sum would send a 1 where a 0 is expected in the parity position. The bench changes every format input while transmission is enabled. A design that sampled them continuously would send a frame of the wrong length or with a wrong parity bit. The bench also aborts a frame partway through and checks that the line is high in the same cycle and that no completion pulse follows. A design that finished the frame or registered the gating would fail that check. Finally, the bench times the completion pulse against the final tick and against ready. This catches an off-by-one count, which would drop or add a stop bit.

// File: rtl/uart_frame_tx_pkg.sv
package uart_frame_tx_pkg;

    localparam int MAX_BITS  = 8;
    localparam int MIN_BITS  = MAX_BITS - 1;
    localparam int MAX_STOP  = 2;
    localparam int FRAME_MAX = 1 + MAX_BITS + 1 + MAX_STOP;
    localparam int CNT_W     = $clog2(FRAME_MAX + 1);
    localparam int PAD_W     = FRAME_MAX - MAX_BITS - 1;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_ZERO = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_EVEN = 2'b11
    } par_mode_e;

    typedef struct packed {
        par_mode_e par;
        logic      len8;
        logic      stop2;
    } fmt_t;

    typedef struct packed {
        logic [FRAME_MAX-1:0] bits;
        logic [CNT_W-1:0]     len;
    } frame_t;

    localparam fmt_t FMT_RESET = '{par: PAR_NONE, len8: 1'b1, stop2: 1'b0};

    function automatic logic parity_of(input par_mode_e mode,
                                       input logic [MAX_BITS-1:0] data);
        logic p;
        case (mode)
            PAR_ODD:  p = ~^data;
            PAR_EVEN: p = ^data;
            default:  p = 1'b0;
        endcase
        return p;
    endfunction

    function automatic frame_t build_frame(input fmt_t f,
                                           input logic [MAX_BITS-1:0] d);
        frame_t               fr;
        logic [MAX_BITS-1:0]  on_line;
        logic [MAX_BITS-1:0]  for_par;
        logic [CNT_W-1:0]     nbits;
        logic [CNT_W-1:0]     ppos;
        logic [FRAME_MAX-1:0] one;
        logic                 pbit;
        one     = FRAME_MAX'(1);
        nbits   = f.len8 ? CNT_W'(MAX_BITS) : CNT_W'(MIN_BITS);
        on_line = f.len8 ? d : {1'b1, d[MIN_BITS-1:0]};
        for_par = f.len8 ? d : {1'b0, d[MIN_BITS-1:0]};
        pbit    = parity_of(f.par, for_par);
        ppos    = nbits + CNT_W'(1);
        fr.bits = {{PAD_W{1'b1}}, on_line, 1'b0};
        if (f.par != PAR_NONE) begin
            fr.bits = (fr.bits & ~(one << ppos)) | (FRAME_MAX'(pbit) << ppos);
        end
        fr.len = CNT_W'(1) + nbits
               + ((f.par != PAR_NONE) ? CNT_W'(1) : CNT_W'(0))
               + (f.stop2 ? CNT_W'(2) : CNT_W'(1));
        return fr;
    endfunction

endpackage

// File: rtl/tfx_fmt_hold.sv
module tfx_fmt_hold
    import uart_frame_tx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tx_en,
    input  fmt_t fmt_in,
    output fmt_t fmt_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            fmt_q <= FMT_RESET;
        end else if (!tx_en) begin
            fmt_q <= fmt_in;
        end
    end

endmodule

// File: rtl/tfx_framer.sv
module tfx_framer
    import uart_frame_tx_pkg::*;
(
    input  fmt_t                fmt,
    input  logic [MAX_BITS-1:0] data,
    output frame_t              frame
);

    always_comb begin
        frame = build_frame(fmt, data);
    end

endmodule

// File: rtl/tfx_shifter.sv
module tfx_shifter
    import uart_frame_tx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   active,
    input  logic   load,
    input  frame_t frame,
    input  logic   tick,
    output logic   txd,
    output logic   busy,
    output logic   done
);

    logic [FRAME_MAX-1:0] shreg;
    logic [CNT_W-1:0]     remain;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            shreg  <= '1;
            remain <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                shreg  <= frame.bits;
                remain <= frame.len;
                busy   <= 1'b1;
            end else if (busy && tick) begin
                shreg  <= {1'b1, shreg[FRAME_MAX-1:1]};
                remain <= remain - CNT_W'(1);
                if (remain == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // Gating with active makes an abort reach the line in the same cycle.
    assign txd = !active || !busy || shreg[0];

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_frame_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_en,
    input  logic       tx_en,
    input  logic [1:0] par_sel,
    input  logic       len8,
    input  logic       stop2,
    input  logic [7:0] din,
    input  logic       din_valid,
    output logic       din_ready,
    input  logic       baud_tick,
    output logic       txd,
    output logic       tx_done
);

    fmt_t   fmt_in;
    fmt_t   fmt_q;
    frame_t frame;
    logic   active;
    logic   busy;
    logic   load;

    assign fmt_in    = '{par: par_mode_e'(par_sel), len8: len8, stop2: stop2};
    assign active    = pwr_en && tx_en;
    assign din_ready = active && !busy;
    assign load      = din_valid && din_ready;

    tfx_fmt_hold u_fmt (
        .clk    (clk),
        .rst    (rst),
        .tx_en  (tx_en),
        .fmt_in (fmt_in),
        .fmt_q  (fmt_q)
    );

    tfx_framer u_framer (
        .fmt   (fmt_q),
        .data  (din),
        .frame (frame)
    );

    tfx_shifter u_shift (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .load   (load),
        .frame  (frame),
        .tick   (baud_tick),
        .txd    (txd),
        .busy   (busy),
        .done   (tx_done)
    );

endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk
    import uart_frame_tx_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic pwr_en,
    input logic tx_en,
    input logic din_valid,
    input logic din_ready,
    input logic txd,
    input logic tx_done,
    input logic busy,
    input fmt_t fmt_q
);

    a_r1_idle_line: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd);

    a_r2_ready_gate: assert property (@(posedge clk) disable iff (rst)
        din_ready |-> (pwr_en && tx_en));

    a_r3_start_bit: assert property (@(posedge clk) disable iff (rst)
        (din_valid && din_ready) |=> (!txd || !(pwr_en && tx_en)));

    a_r7_fmt_frozen: assert property (@(posedge clk) disable iff (rst)
        (tx_en && $past(tx_en)) |-> $stable(fmt_q));

    a_r8_abort_quiet: assert property (@(posedge clk) disable iff (rst)
        !tx_en |-> (txd && !din_ready));

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> !tx_done);

    a_r9_ready_with_done: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> (din_ready || !(pwr_en && tx_en)));

endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .pwr_en    (pwr_en),
    .tx_en     (tx_en),
    .din_valid (din_valid),
    .din_ready (din_ready),
    .txd       (txd),
    .tx_done   (tx_done),
    .busy      (busy),
    .fmt_q     (fmt_q)
);

// File: tb/uart_frame_tx_bench.sv
module uart_frame_tx_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwr_en = 1'b0;
    logic       tx_en = 1'b0;
    logic [1:0] par_sel = 2'b00;
    logic       len8 = 1'b1;
    logic       stop2 = 1'b0;
    logic [7:0] din = 8'h00;
    logic       din_valid = 1'b0;
    logic       din_ready;
    logic       baud_tick = 1'b0;
    logic       txd;
    logic       tx_done;

    int checks = 0;
    int fails  = 0;

    logic [1:0] m_par   = 2'b00;
    logic       m_len8  = 1'b1;
    logic       m_stop2 = 1'b0;

    always #2.5 clk = ~clk;

    uart_frame_tx u_uart_frame_tx (
        .clk       (clk),
        .rst       (rst),
        .pwr_en    (pwr_en),
        .tx_en     (tx_en),
        .par_sel   (par_sel),
        .len8      (len8),
        .stop2     (stop2),
        .din       (din),
        .din_valid (din_valid),
        .din_ready (din_ready),
        .baud_tick (baud_tick),
        .txd       (txd),
        .tx_done   (tx_done)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic void model(input logic [7:0] d, output logic [11:0] b, output int n);
        int k;
        int ones;
        int nb;
        k = 0; ones = 0; b = '1;
        nb = m_len8 ? 8 : 7;
        b[k] = 1'b0; k++;
        for (int i = 0; i < nb; i++) begin
            b[k] = d[i]; ones += int'(d[i]); k++;
        end
        if (m_par != 2'b00) begin
            if (m_par == 2'b01)      b[k] = 1'b0;
            else if (m_par == 2'b10) b[k] = (ones % 2 == 0);
            else                     b[k] = (ones % 2 == 1);
            k++;
        end
        b[k] = 1'b1; k++;
        if (m_stop2) begin b[k] = 1'b1; k++; end
        n = k;
    endfunction

    task automatic set_fmt(input logic [1:0] p, input logic l8, input logic s2);
        @(negedge clk);
        tx_en = 1'b0; par_sel = p; len8 = l8; stop2 = s2;
        m_par = p; m_len8 = l8; m_stop2 = s2;
        @(negedge clk);
        tx_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_frame(input logic [7:0] d, input string req);
        logic [11:0] eb;
        int n;
        model(d, eb, n);
        chk(din_ready == 1'b1, {req, " ready before send"}, int'(din_ready), 1);
        din = d; din_valid = 1'b1;
        @(negedge clk);
        din_valid = 1'b0;
        chk(din_ready == 1'b0, {req, " R2 busy"}, int'(din_ready), 0);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(txd == eb[i], $sformatf("%s R3 bit %0d", req, i), int'(txd), int'(eb[i]));
            chk(tx_done == 1'b0, {req, " R9 early done"}, int'(tx_done), 0);
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
        end
        chk(tx_done == 1'b1, {req, " R9 done pulse"}, int'(tx_done), 1);
        chk(din_ready == 1'b1, {req, " R9 ready with done"}, int'(din_ready), 1);
        chk(txd == 1'b1, {req, " R1 idle after frame"}, int'(txd), 1);
        @(negedge clk);
        chk(tx_done == 1'b0, {req, " R9 pulse width"}, int'(tx_done), 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(txd == 1'b1, "R1 txd in reset", int'(txd), 1);
        chk(din_ready == 1'b0, "R1 ready in reset", int'(din_ready), 0);
        chk(tx_done == 1'b0, "R1 done in reset", int'(tx_done), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(din_ready == 1'b0, "R2 ready with power off", int'(din_ready), 0);
        pwr_en = 1'b1;
        @(negedge clk);
        chk(din_ready == 1'b0, "R2 ready with tx_en off", int'(din_ready), 0);
    endtask

    task automatic t_power_gate;
        set_fmt(2'b00, 1'b1, 1'b0);
        pwr_en = 1'b0; din = 8'h3C; din_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk(din_ready == 1'b0, "R2 no ready without power", int'(din_ready), 0);
        chk(txd == 1'b1, "R2 line idle without power", int'(txd), 1);
        din_valid = 1'b0;
        tx_en = 1'b0;
        @(negedge clk);
        pwr_en = 1'b1;
        @(negedge clk);
        tx_en = 1'b1;
        @(negedge clk);
        chk(din_ready == 1'b1, "R2 ready after power up", int'(din_ready), 1);
    endtask

    task automatic t_modes;
        set_fmt(2'b00, 1'b1, 1'b0); run_frame(8'hA5, "R3 R4 8N1");
        set_fmt(2'b00, 1'b1, 1'b1); run_frame(8'h0F, "R6 two stops");
        set_fmt(2'b01, 1'b1, 1'b0); run_frame(8'hFF, "R5 zero parity");
        set_fmt(2'b10, 1'b1, 1'b0); run_frame(8'h07, "R5 odd parity");
        set_fmt(2'b11, 1'b1, 1'b1); run_frame(8'h07, "R5 even parity");
        set_fmt(2'b11, 1'b1, 1'b0); run_frame(8'h66, "R5 even parity even data");
        set_fmt(2'b10, 1'b0, 1'b0); run_frame(8'h81, "R4 seven bit odd");
        set_fmt(2'b00, 1'b0, 1'b1); run_frame(8'hFE, "R4 seven bit no parity");
    endtask

    task automatic t_fmt_lock;
        set_fmt(2'b00, 1'b1, 1'b0);
        par_sel = 2'b11; len8 = 1'b0; stop2 = 1'b1;
        repeat (2) @(negedge clk);
        run_frame(8'h5A, "R7 change while enabled");
        set_fmt(2'b11, 1'b0, 1'b1);
        run_frame(8'h5A, "R7 applied after disable");
    endtask

    task automatic t_abort;
        set_fmt(2'b00, 1'b1, 1'b1);
        din = 8'h00; din_valid = 1'b1;
        @(negedge clk);
        din_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            baud_tick = 1'b1; @(negedge clk); baud_tick = 1'b0; @(negedge clk);
        end
        chk(txd == 1'b0, "R3 data zero before abort", int'(txd), 0);
        tx_en = 1'b0;
        #1;
        chk(txd == 1'b1, "R8 line high at once", int'(txd), 1);
        chk(din_ready == 1'b0, "R8 not ready while disabled", int'(din_ready), 0);
        for (int i = 0; i < 20; i++) begin
            baud_tick = (i % 2 == 0);
            @(negedge clk);
            chk(tx_done == 1'b0, "R8 no done after abort", int'(tx_done), 0);
        end
        baud_tick = 1'b0;
        tx_en = 1'b1;
        @(negedge clk);
        chk(din_ready == 1'b1, "R8 ready after re-enable", int'(din_ready), 1);
        chk(txd == 1'b1, "R8 idle after re-enable", int'(txd), 1);
    endtask

    task automatic t_idle_ticks;
        set_fmt(2'b00, 1'b1, 1'b0);
        for (int i = 0; i < 10; i++) begin
            baud_tick = 1'b1;
            @(negedge clk);
            chk(txd == 1'b1, "R10 idle tick line", int'(txd), 1);
            chk(tx_done == 1'b0, "R10 idle tick done", int'(tx_done), 0);
        end
        baud_tick = 1'b0;
        run_frame(8'hC3, "R10 frame after idle ticks");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_power_gate();
        t_modes();
        t_fmt_lock();
        t_abort();
        t_idle_ticks();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule